// File: doc/BRIEF.md
# Multi-Line Serial Audio Receiver

This block turns three serial PCM audio lines into parallel stereo samples. The three data lines share one bit clock and one left/right (word-select) clock, and all of these come from an external source. The block is always a clock slave. It samples them with its own system clock. A configuration input picks the serial format and word length: right-justified at 24 or 20 bits, or I2S at 16 or 24 bits. A second configuration input chooses which bit-clock edge samples the data and the left/right clock.

Each data line produces a 24-bit left word and a 24-bit right word. Words shorter than 24 bits are MSB-aligned, with the unused low bits set to zero. When a left word and the right word that follows it have both been captured, the block raises a single-cycle frame strobe. The new words are on the outputs in the same cycle as the strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_sel` chooses the format. 2'b00 is 24-bit right-justified, 2'b01 is 20-bit right-justified, 2'b10 is 16-bit I2S and 2'b11 is 24-bit I2S.
- R2: With `bclk_inv` = 0, data and `lrclk` are sampled on rising edges of `bclk`. With `bclk_inv` = 1 they are sampled on falling edges instead.
- R3: The three data lines are captured independently under the shared clocks. Line k drives bits [24k+23:24k] of `left_word` and `right_word`.
- R4: In I2S formats, the MSB is sampled one bit clock after the `lrclk` change that opens the slot. `lrclk` low marks the left slot.
- R5: In right-justified formats, the LSB is the last bit sampled before the `lrclk` change that closes the slot. `lrclk` high marks the left slot. Bits earlier in the slot than the word itself are ignored.
- R6: A word of N < 24 bits is delivered as value << (24-N), so its low 24-N bits are zero.
- R7: In 24-bit I2S, a slot longer than 24 bit clocks is accepted. Only the first 24 bits after the MSB position are kept, and any later bits in the slot are ignored.
- R8: `frame_valid` is a one-cycle pulse. It fires only when a right word completes after a left word. The first `lrclk` change after reset opens a slot but completes no word.
- R9: Word outputs and `frame_valid` change on the third `clk` rising edge after the `bclk` sampling edge that carries the closing `lrclk` change. Between updates the word outputs hold their values.
- R10: While reset is asserted, all word outputs and `frame_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `bclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_sel | input | 2 | Format and word-length select (R1) |
| bclk_inv | input | 1 | 1 selects falling-edge sampling |
| bclk | input | 1 | Serial bit clock from the external source |
| lrclk | input | 1 | Left/right word clock from the external source |
| sdata | input | NLINES | Serial data lines |
| left_word | output | NLINES*24 | Left samples, one 24-bit field per line |
| right_word | output | NLINES*24 | Right samples, one 24-bit field per line |
| frame_valid | output | 1 | One-cycle strobe when a left/right pair is complete |

## Verification
Serial inputs pass through a two-stage synchroniser, and edge detection uses the second stage. A sampling edge of `bclk` therefore becomes an internal tick in the cycle after the second `clk` edge, and the registered words and `frame_valid` appear after the third edge. The bench drives every input on falling `clk` edges and restarts a cycle count at each sampling edge it drives. For each strobe, it records that count, which must be exactly three. It also captures the words at the strobe. The captured words are then compared with values that the bench computes arithmetically for every format and both sampling polarities.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  localparam int unsigned SAR_WORD_W = 24;
  localparam int unsigned SAR_CNT_W  = $clog2(SAR_WORD_W + 1);

  typedef logic [SAR_WORD_W-1:0] sar_word_t;
  typedef logic [SAR_CNT_W-1:0]  sar_cnt_t;

  typedef enum logic [1:0] {
    FMT_RJ24  = 2'b00,
    FMT_RJ20  = 2'b01,
    FMT_I2S16 = 2'b10,
    FMT_I2S24 = 2'b11
  } sar_fmt_e;

  function automatic logic fmt_is_i2s(input logic [1:0] f);
    return f[1];
  endfunction

  function automatic sar_cnt_t fmt_bits(input logic [1:0] f);
    case (f)
      FMT_RJ20:  return sar_cnt_t'(20);
      FMT_I2S16: return sar_cnt_t'(16);
      default:   return sar_cnt_t'(SAR_WORD_W);
    endcase
  endfunction

  // Keep the low n bits of a shift history and move them to the top.
  function automatic sar_word_t rj_align(input sar_word_t hist, input sar_cnt_t n);
    sar_word_t mask;
    mask = {SAR_WORD_W{1'b1}} >> (SAR_WORD_W - int'(n));
    return (hist & mask) << (SAR_WORD_W - int'(n));
  endfunction

  // Write bit b at MSB-first position pos if it is inside the word.
  function automatic sar_word_t msb_place(input sar_word_t acc, input logic b,
                                          input sar_cnt_t pos, input sar_cnt_t n);
    sar_word_t r;
    r = acc;
    if (b && (pos < n)) r[SAR_WORD_W-1-int'(pos)] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/sar_input_sync.sv
module sar_input_sync #(
  parameter int unsigned NLINES      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_inv,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic [NLINES-1:0] sdata,
  output logic              tick,
  output logic              lr_s,
  output logic [NLINES-1:0] data_s
);
  localparam int unsigned SW = NLINES + 2;

  logic [SW-1:0] chain [SYNC_STAGES];
  logic          bclk_prev;
  logic          bclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) chain[i] <= '0;
      bclk_prev <= 1'b0;
    end else begin
      chain[0] <= {sdata, lrclk, bclk};
      for (int i = 1; i < int'(SYNC_STAGES); i++) chain[i] <= chain[i-1];
      bclk_prev <= chain[SYNC_STAGES-1][0];
    end
  end

  assign bclk_s = chain[SYNC_STAGES-1][0];
  assign lr_s   = chain[SYNC_STAGES-1][1];
  assign data_s = chain[SYNC_STAGES-1][SW-1:2];

  always_comb begin
    if (bclk_inv) tick = bclk_prev & ~bclk_s;
    else          tick = ~bclk_prev & bclk_s;
  end
endmodule

// File: rtl/sar_slot_tracker.sv
module sar_slot_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic is_i2s,
  input  logic tick,
  input  logic lr_s,
  output logic bound,
  output logic emit,
  output logic emit_left,
  output logic frame_done
);
  logic seen, started, lr_prev, got_left;

  always_comb begin
    bound      = tick && seen && (lr_s != lr_prev);
    emit       = bound && started;
    emit_left  = is_i2s ? ~lr_prev : lr_prev;
    frame_done = emit && !emit_left && got_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      started  <= 1'b0;
      lr_prev  <= 1'b0;
      got_left <= 1'b0;
    end else if (tick) begin
      seen    <= 1'b1;
      lr_prev <= lr_s;
      if (bound) started <= 1'b1;
      if (emit)  got_left <= emit_left;
    end
  end
endmodule

// File: rtl/sar_lane.sv
module sar_lane
  import serial_audio_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      is_i2s,
  input  sar_cnt_t  nbits,
  input  logic      tick,
  input  logic      bound,
  input  logic      din,
  output sar_word_t word
);
  sar_word_t hist, acc, acc_next;
  sar_cnt_t  cnt;

  always_comb begin
    acc_next = msb_place(acc, din, cnt, nbits);
    word     = is_i2s ? acc_next : rj_align(hist, nbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      acc  <= '0;
      cnt  <= '0;
    end else if (tick) begin
      hist <= {hist[SAR_WORD_W-2:0], din};
      if (bound) begin
        acc <= '0;
        cnt <= '0;
      end else begin
        acc <= acc_next;
        if (cnt < nbits) cnt <= cnt + sar_cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int unsigned NLINES      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   fmt_sel,
  input  logic                         bclk_inv,
  input  logic                         bclk,
  input  logic                         lrclk,
  input  logic [NLINES-1:0]            sdata,
  output logic [NLINES*SAR_WORD_W-1:0] left_word,
  output logic [NLINES*SAR_WORD_W-1:0] right_word,
  output logic                         frame_valid
);
  localparam int unsigned W = SAR_WORD_W;

  logic              tick, lr_s, bound, emit, emit_left, frame_done, is_i2s;
  logic [NLINES-1:0] data_s;
  sar_cnt_t          nbits;
  sar_word_t         lane_word [NLINES];

  assign is_i2s = fmt_is_i2s(fmt_sel);
  assign nbits  = fmt_bits(fmt_sel);

  sar_input_sync #(.NLINES(NLINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_inv(bclk_inv), .bclk(bclk), .lrclk(lrclk),
    .sdata(sdata), .tick(tick), .lr_s(lr_s), .data_s(data_s)
  );

  sar_slot_tracker u_track (
    .clk(clk), .rst_n(rst_n), .is_i2s(is_i2s), .tick(tick), .lr_s(lr_s),
    .bound(bound), .emit(emit), .emit_left(emit_left), .frame_done(frame_done)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_lane
    sar_lane u_lane (
      .clk(clk), .rst_n(rst_n), .is_i2s(is_i2s), .nbits(nbits), .tick(tick),
      .bound(bound), .din(data_s[g]), .word(lane_word[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        left_word[g*W +: W]  <= '0;
        right_word[g*W +: W] <= '0;
      end else if (emit) begin
        if (emit_left) left_word[g*W +: W]  <= lane_word[g];
        else           right_word[g*W +: W] <= lane_word[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_valid <= 1'b0;
    else        frame_valid <= frame_done;
  end
endmodule

// File: rtl/serial_audio_rx_sva.sv
module serial_audio_rx_sva #(
  parameter int unsigned WW = 72
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          bound,
  input logic          emit,
  input logic          emit_left,
  input logic          frame_valid,
  input logic [WW-1:0] left_word,
  input logic [WW-1:0] right_word
);
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_emit_needs_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> bound);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  p_valid_after_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(emit && !emit_left));

  p_left_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(emit && emit_left) |-> $stable(left_word));

  p_right_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(emit && !emit_left) |-> $stable(right_word));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r10: assert (frame_valid == 1'b0 || $isunknown(frame_valid));
    end
  end
endmodule

bind serial_audio_rx serial_audio_rx_sva #(.WW(NLINES*serial_audio_rx_pkg::SAR_WORD_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bound(bound), .emit(emit),
  .emit_left(emit_left), .frame_valid(frame_valid),
  .left_word(left_word), .right_word(right_word)
);

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
  localparam int NL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    fmt_sel = 2'b00;
  logic          bclk_inv = 1'b0;
  logic          bclk = 1'b0;
  logic          lrclk = 1'b0;
  logic [NL-1:0] sdata = '0;
  logic [NL*24-1:0] left_word, right_word;
  logic          frame_valid;

  int n_cmp = 0, n_bad = 0, since_edge = 0, fv_cnt = 0, lat_bad = 0;
  bit done = 0;
  logic [23:0] cap_l [8][NL];
  logic [23:0] cap_r [8][NL];

  always #5 clk = ~clk;

  serial_audio_rx uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk_inv(bclk_inv), .bclk(bclk),
    .lrclk(lrclk), .sdata(sdata), .left_word(left_word), .right_word(right_word),
    .frame_valid(frame_valid)
  );

  always @(posedge clk) since_edge <= since_edge + 1;

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      if (fv_cnt < 8)
        for (int k = 0; k < NL; k++) begin
          cap_l[fv_cnt][k] = left_word[k*24 +: 24];
          cap_r[fv_cnt][k] = right_word[k*24 +: 24];
        end
      if (since_edge != 3) lat_bad++;
      fv_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] val_of(input int f, input int ch, input int ln, input int n);
    logic [31:0] h;
    h = 32'(f * 7 + ch * 3 + ln * 13 + 1) * 32'h9E3779B1;
    h = h ^ (h >> 11);
    return h[23:0] & (24'hFFFFFF >> (24 - n));
  endfunction

  function automatic logic [23:0] word_of(input int s, input int ln, input int n);
    if (s < 1 || s > 6) return 24'h0;
    return val_of((s - 1) / 2, (s - 1) % 2, ln, n);
  endfunction

  // Serial content of a slot at logical position q; filler bits are ones.
  function automatic logic raw_bit(input logic [23:0] v, input int q, input int n,
                                   input int slot, input bit i2s);
    if (i2s) return (q < n) ? v[n - 1 - q] : 1'b1;
    return (q >= slot - n) ? v[n - 1 - (q - (slot - n))] : 1'b1;
  endfunction

  task automatic drive_bit(input logic lr, input logic [NL-1:0] d);
    @(negedge clk);
    lrclk = lr; sdata = d; bclk = bclk_inv;
    repeat (4) @(negedge clk);
    bclk = ~bclk_inv;
    since_edge = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_cfg(input logic [1:0] f, input logic inv);
    int  n, slot;
    bit  i2s;
    string tag;
    i2s  = f[1];
    n    = (f == 2'b01) ? 20 : (f == 2'b10) ? 16 : 24;
    slot = (f == 2'b11 && inv) ? 32 : 24;
    rst_n = 1'b0; fmt_sel = f; bclk_inv = inv; bclk = inv;
    lrclk = i2s ? 1'b1 : 1'b0; sdata = '0;
    repeat (5) @(negedge clk);
    // R10: reset state
    check("R10 left_word in reset", 32'(left_word[31:0]), 32'h0);
    check("R10 right_word in reset", 32'(right_word[31:0]), 32'h0);
    check("R10 frame_valid in reset", 32'(frame_valid), 32'h0);
    rst_n = 1'b1;
    fv_cnt = 0; lat_bad = 0;
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < slot; p++) begin
        logic lr;
        logic [NL-1:0] d;
        lr = i2s ? ((s % 2 == 1) ? 1'b0 : 1'b1) : ((s % 2 == 1) ? 1'b1 : 1'b0);
        for (int ln = 0; ln < NL; ln++) begin
          if (i2s) begin
            if (p == 0) d[ln] = (s == 0) ? 1'b0 : raw_bit(word_of(s - 1, ln, n), slot - 1, n, slot, 1'b1);
            else        d[ln] = raw_bit(word_of(s, ln, n), p - 1, n, slot, 1'b1);
          end else begin
            d[ln] = raw_bit(word_of(s, ln, n), p, n, slot, 1'b0);
          end
        end
        drive_bit(lr, d);
      end
    end
    repeat (10) @(negedge clk);
    tag = $sformatf("R1 R2 R3 %s%s%s fmt=%0d inv=%0d", i2s ? "R4" : "R5",
                    (n < 24) ? " R6" : "", (slot > 24) ? " R7" : "", f, inv);
    check($sformatf("R8 frame count fmt=%0d inv=%0d", f, inv), 32'(fv_cnt), 32'd3);
    check($sformatf("R9 strobe latency misses fmt=%0d inv=%0d", f, inv), 32'(lat_bad), 32'd0);
    for (int fr = 0; fr < 3; fr++)
      for (int ln = 0; ln < NL; ln++) begin
        check($sformatf("%s frame%0d line%0d left", tag, fr, ln),
              32'(cap_l[fr][ln]), 32'(val_of(fr, 0, ln, n) << (24 - n)));
        check($sformatf("%s frame%0d line%0d right", tag, fr, ln),
              32'(cap_r[fr][ln]), 32'(val_of(fr, 1, ln, n) << (24 - n)));
      end
    // R9: words hold after the last frame although a new left slot is open
    check($sformatf("R9 hold left fmt=%0d inv=%0d", f, inv),
          32'(left_word[23:0]), 32'(val_of(2, 0, 0, n) << (24 - n)));
  endtask

  initial begin
    for (int f = 0; f < 4; f++)
      for (int inv = 0; inv < 2; inv++)
        run_cfg(2'(f), 1'(inv));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule